// File: doc/BRIEF.md
# H-Bridge Fault Protection Controller

This block sits beside the gate driver of an H-bridge made of two half-bridges and decides, cycle by cycle, whether each half-bridge may be driven. Each half-bridge has a drive request. The block grants it only while no fault holds the outputs off. The fault inputs are already synchronous digital levels: supply over-voltage and under-voltage comparators, a junction over-temperature comparator, one drain-source overcurrent comparator for each half-bridge, and a pulse for each half-bridge that marks the start of a switching slope.

Supply faults take the outputs off at once and give them back as soon as the supply is in range again. An over-temperature condition must persist for a fixed number of cycles before a sticky thermal flag sets and turns everything off. That flag stays set until software issues a clear strobe while the die is no longer hot. Overcurrent is not checked during a blanking window that follows each slope start. Outside that window, an overcurrent must persist for two cycles in a row before the block latches it. A bridge-mode bit selects whether a latched overcurrent kills the whole bridge or only its own half. A 3-bit overcurrent threshold selection is registered and handed to the threshold DAC.

Top module: `bridge_fault_guard`

## Requirements
- R1: While supply_ov or supply_uv is 1, both drv_en bits are 0 and fault_err is 1 in the same cycle. While rst_n is 0, drv_en is 00.
- R2: Once both supply inputs return to 0 and no other fault is held, drv_en equals drv_req again in the same cycle.
- R3: tsd_flag becomes 1 after TSD_DLY consecutive clock edges with temp_hi at 1. While tsd_flag is 1, drv_en is 00.
- R4: If temp_hi drops to 0 before the delay expires, the delay count restarts from zero.
- R5: tsd_flag stays at 1 until a clock edge at which fault_clr is 1 and temp_hi is 0. A clear strobe given while temp_hi is 1 has no effect.
- R6: An overcurrent on half h is ignored during the edge at which slope_start[h] is 1 and during the BLANK-1 edges that follow.
- R7: An overcurrent latches only when oc_cmp[h] is 1 and unblanked on two consecutive edges. A single-cycle pulse does not latch.
- R8: With half_mode at 0, a latched overcurrent on either half forces drv_en to 00.
- R9: With half_mode at 1, a latched overcurrent on half h forces only drv_en[h] to 0.
- R10: A latched overcurrent holds after oc_cmp returns to 0, and is cleared at an edge where fault_clr is 1.
- R11: dac_code takes the value of oc_level one clock edge later.
- R12: fault_err is the OR of the supply faults and any latched overcurrent. It does not include the thermal fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_req | input | 2 | Drive request per half-bridge |
| supply_ov | input | 1 | Supply over-voltage comparator |
| supply_uv | input | 1 | Supply under-voltage comparator |
| temp_hi | input | 1 | Junction over-temperature comparator |
| oc_cmp | input | 2 | Drain-source overcurrent comparator per half-bridge |
| slope_start | input | 2 | Pulse marking the start of a switching slope per half-bridge |
| oc_level | input | 3 | Overcurrent threshold selection |
| half_mode | input | 1 | 0: whole bridge trips, 1: only the faulty half trips |
| fault_clr | input | 1 | Clear strobe for latched faults |
| drv_en | output | 2 | Enable per half-bridge |
| tsd_flag | output | 1 | Sticky thermal shutdown flag |
| fault_err | output | 1 | Combined supply and overcurrent fault flag |
| dac_code | output | 3 | Registered threshold code for the DAC |

## Verification
The hardest case to reach is the exact edge of the blanking window. An overcurrent that is already present when a slope starts must be ignored through the whole window. It must then be counted over two clean cycles, and only after that may it trip the bridge. The stimulus holds oc_cmp high across a slope_start pulse and checks drv_en on every edge until the trip appears on the sixth edge. A similar count covers the thermal delay. There, temp_hi drops one edge short of expiry and the bench shows that a fresh full run of edges is needed before the trip.

// File: rtl/bridge_fault_guard.sv
module bridge_fault_guard #(
  parameter int TSD_DLY = 8,
  parameter int BLANK   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] drv_req,
  input  logic       supply_ov,
  input  logic       supply_uv,
  input  logic       temp_hi,
  input  logic [1:0] oc_cmp,
  input  logic [1:0] slope_start,
  input  logic [2:0] oc_level,
  input  logic       half_mode,
  input  logic       fault_clr,
  output logic [1:0] drv_en,
  output logic       tsd_flag,
  output logic       fault_err,
  output logic [2:0] dac_code
);
  localparam int TW = $clog2(TSD_DLY + 1);
  localparam int BW = $clog2(BLANK + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TSD_DLY - 1);
  localparam logic [BW-1:0] B_LOAD = BW'(BLANK - 1);

  logic [TW-1:0] tcnt;
  logic          tsd_q;
  logic [1:0]    oc_lat;
  logic [1:0]    kill;
  logic          supply_bad;

  assign supply_bad = supply_ov | supply_uv;

  always_ff @(posedge clk) begin
    if (!rst_n)                 tcnt <= '0;
    else if (!temp_hi)          tcnt <= '0;
    else if (tcnt != T_LAST)    tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         tsd_q <= 1'b0;
    else if (temp_hi && tcnt == T_LAST) tsd_q <= 1'b1;
    else if (fault_clr && !temp_hi)     tsd_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dac_code <= '0;
    else        dac_code <= oc_level;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [BW-1:0] bcnt;
    logic          seen, lat, blank, hit;

    assign blank = slope_start[h] | (bcnt != '0);
    assign hit   = oc_cmp[h] & ~blank;

    always_ff @(posedge clk) begin
      if (!rst_n)              bcnt <= '0;
      else if (slope_start[h]) bcnt <= B_LOAD;
      else if (bcnt != '0)     bcnt <= bcnt - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || fault_clr) begin
        seen <= 1'b0;
        lat  <= 1'b0;
      end else begin
        seen <= hit;
        if (hit && seen) lat <= 1'b1;
      end
    end

    assign oc_lat[h] = lat;

    a_r6_blanked_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
      slope_start[h] && !fault_clr |=> $stable(oc_lat[h]));
  end

  assign kill      = half_mode ? oc_lat : {2{|oc_lat}};
  assign drv_en    = drv_req & ~kill & {2{~(supply_bad | tsd_q) & rst_n}};
  assign tsd_flag  = tsd_q;
  assign fault_err = supply_bad | (|oc_lat);

  a_r1_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    supply_bad |-> drv_en == 2'b00);
  a_r3_tsd_off: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag |-> drv_en == 2'b00);
  a_r5_tsd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag && !(fault_clr && !temp_hi) |=> tsd_flag);
  a_r7_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_lat[0]) |-> $past(oc_cmp[0]) && $past(oc_cmp[0], 2));
  a_r8_full_trip: assert property (@(posedge clk) disable iff (!rst_n)
    !half_mode && (|oc_lat) |-> drv_en == 2'b00);
  a_r9_half_trip: assert property (@(posedge clk) disable iff (!rst_n)
    half_mode && oc_lat == 2'b01 |-> !drv_en[0]);
  a_r11_dac: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> dac_code == $past(oc_level));
endmodule

// File: tb/sim_bridge_fault_guard.sv
module sim_bridge_fault_guard;
  logic clk = 0, rst_n = 0;
  logic [1:0] drv_req = 2'b11, oc_cmp = 0, slope_start = 0;
  logic supply_ov = 0, supply_uv = 0, temp_hi = 0, half_mode = 0, fault_clr = 0;
  logic [2:0] oc_level = 3'd5;
  logic [1:0] drv_en;
  logic tsd_flag, fault_err;
  logic [2:0] dac_code;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [6:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  bridge_fault_guard #(.TSD_DLY(8), .BLANK(4)) u0 (
    .clk(clk), .rst_n(rst_n), .drv_req(drv_req), .supply_ov(supply_ov),
    .supply_uv(supply_uv), .temp_hi(temp_hi), .oc_cmp(oc_cmp),
    .slope_start(slope_start), .oc_level(oc_level), .half_mode(half_mode),
    .fault_clr(fault_clr), .drv_en(drv_en), .tsd_flag(tsd_flag),
    .fault_err(fault_err), .dac_code(dac_code));

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [6:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {drv_en, tsd_flag, fault_err, dac_code};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual en=%b tsd=%b err=%b dac=%0d expected en=%b tsd=%b err=%b dac=%0d",
                 t, a[6:5], a[4], a[3], a[2:0], e[6:5], e[4], e[3], e[2:0]);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(logic [1:0] en, logic tsd, logic err, logic [2:0] dac, string tag);
    exp_q.push_back({en, tsd, err, dac});
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
    @(posedge clk);
    #1;
  endtask

  initial begin
    step(2);
    chk(2'b00, 0, 0, 3'd0, "R1 reset outputs off");
    rst_n = 1;
    chk(2'b11, 0, 0, 3'd0, "R2 idle after reset");
    chk(2'b11, 0, 0, 3'd5, "R11 dac loaded");
    oc_level = 3'd3;
    chk(2'b11, 0, 0, 3'd5, "R11 dac before edge");
    chk(2'b11, 0, 0, 3'd3, "R11 dac after edge");
    supply_ov = 1;
    chk(2'b00, 0, 1, 3'd3, "R1 over-voltage off");
    supply_ov = 0; supply_uv = 1;
    chk(2'b00, 0, 1, 3'd3, "R12 under-voltage error");
    supply_uv = 0;
    chk(2'b11, 0, 0, 3'd3, "R2 supply release");
    // single-cycle overcurrent pulse
    oc_cmp = 2'b01;
    chk(2'b11, 0, 0, 3'd3, "R7 pulse first edge");
    oc_cmp = 2'b00;
    chk(2'b11, 0, 0, 3'd3, "R7 pulse not latched");
    oc_cmp = 2'b01;
    chk(2'b11, 0, 0, 3'd3, "R7 first of two");
    chk(2'b11, 0, 0, 3'd3, "R7 before latch");
    chk(2'b00, 0, 1, 3'd3, "R8 full bridge trip");
    oc_cmp = 2'b00;
    chk(2'b00, 0, 1, 3'd3, "R10 latch holds");
    fault_clr = 1;
    chk(2'b00, 0, 1, 3'd3, "R10 clear edge");
    fault_clr = 0;
    chk(2'b11, 0, 0, 3'd3, "R10 cleared");
    // half-bridge mode
    half_mode = 1; oc_cmp = 2'b10;
    chk(2'b11, 0, 0, 3'd3, "R9 first edge");
    chk(2'b11, 0, 0, 3'd3, "R9 second edge");
    chk(2'b01, 0, 1, 3'd3, "R9 only half 1 off");
    oc_cmp = 2'b00; fault_clr = 1;
    chk(2'b01, 0, 1, 3'd3, "R9 clear edge");
    fault_clr = 0;
    chk(2'b11, 0, 0, 3'd3, "R10 half cleared");
    // blanking window
    half_mode = 0; slope_start = 2'b01; oc_cmp = 2'b01;
    chk(2'b11, 0, 0, 3'd3, "R6 slope start");
    slope_start = 2'b00;
    chk(2'b11, 0, 0, 3'd3, "R6 blank 2");
    chk(2'b11, 0, 0, 3'd3, "R6 blank 3");
    chk(2'b11, 0, 0, 3'd3, "R6 blank 4");
    chk(2'b11, 0, 0, 3'd3, "R6 first unblanked");
    chk(2'b11, 0, 0, 3'd3, "R6 R7 before trip");
    chk(2'b00, 0, 1, 3'd3, "R6 trip after window");
    oc_cmp = 2'b00; fault_clr = 1;
    chk(2'b00, 0, 1, 3'd3, "R10 clear edge");
    fault_clr = 0;
    chk(2'b11, 0, 0, 3'd3, "R10 cleared again");
    // thermal delay with restart
    temp_hi = 1;
    step(6);
    chk(2'b11, 0, 0, 3'd3, "R3 not yet");
    temp_hi = 0;
    chk(2'b11, 0, 0, 3'd3, "R4 drop");
    temp_hi = 1;
    step(7);
    chk(2'b11, 0, 0, 3'd3, "R4 restarted count");
    chk(2'b00, 1, 0, 3'd3, "R3 thermal trip");
    temp_hi = 0;
    chk(2'b00, 1, 0, 3'd3, "R5 sticky");
    temp_hi = 1; fault_clr = 1;
    chk(2'b00, 1, 0, 3'd3, "R5 clear while hot");
    temp_hi = 0;
    chk(2'b00, 1, 0, 3'd3, "R5 clear ignored when hot");
    fault_clr = 0;
    chk(2'b11, 0, 0, 3'd3, "R5 cleared when cool");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule